// File: doc/BRIEF.md
# Three-wire stepping potentiometer host sequencer

This block is the host side of a digital potentiometer that is moved one tap at a time over three wires: an active-low select, a direction level and an active-low step strobe. Logic elsewhere in the chip hands it one command at a time. A command carries a step count, a direction and a flag that says whether the new wiper position is committed to the part's non-volatile memory. The sequencer then produces the whole select, step and deselect waveform on its own. It raises `busy` for the length of the session and pulses `done` once at the end.

Every minimum interval on the wires is derived from a clock frequency parameter and a time parameter in nanoseconds. Each interval is rounded up to whole clock cycles. The intervals are: select setup, direction setup, low and high step phases, release setup, and the two deselect holds. The step strobe level at the moment select is released tells the part whether to store. A commit leaves the strobe high and waits the long hold. A skip parks the strobe low and waits only the short hold. A command with a step count of zero still opens and closes a session, so a store-only command is possible.

Top module: `potstep_seq`

## Requirements
- R1: After reset `pot_cs_n`=1, `pot_inc`=1, `busy`=0 and `done`=0.
- R2: A command with step count N makes exactly N high-to-low transitions of `pot_inc` while `pot_cs_n`=0. During the whole session `pot_up` equals the command's direction bit (1 = up).
- R3: At least ceil(T_SEL_NS·f) cycles pass between the fall of `pot_cs_n` and the first fall of `pot_inc`.
- R4: `pot_up` stays stable for at least ceil(T_DIR_NS·f) cycles before every fall of `pot_inc` in a session. It changes only while `pot_cs_n`=1.
- R5: Within a session each low phase of `pot_inc` lasts at least ceil(T_LOW_NS·f) cycles, and each high phase between two steps at least ceil(T_HIGH_NS·f) cycles.
- R6: At least ceil(T_REL_NS·f) cycles separate the last `pot_inc` transition from the rise of `pot_cs_n`.
- R7: When `pot_cs_n` rises, `pot_inc` equals the command's store bit (1 = commit, 0 = skip). `pot_cs_n` then stays high for at least ceil(T_STORE_NS·f) cycles for a commit, or ceil(T_SKIP_NS·f) cycles for a skip, before `done`.
- R8: A zero-step command opens and closes a session with no step. With the store bit set it commits the current position.
- R9: `busy` is high from the cycle after acceptance for exactly 2·Csel + Cdir + N·Clow + H·Chigh + Crel + Chold cycles. H is N for a commit and max(N−1,0) for a skip. `done` is a one-cycle pulse in the first cycle with `busy`=0.
- R10: `cmd_valid` is ignored while `busy`=1. The running session's step count and length stay unchanged.
- R11: Outside a session `pot_inc`=1 and `pot_cs_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present; taken when `busy`=0 |
| cmd_steps | input | STEP_W | Number of taps to move |
| cmd_up | input | 1 | Direction, 1 = up |
| cmd_store | input | 1 | 1 = commit the position at release |
| busy | output | 1 | Session in progress |
| done | output | 1 | One-cycle pulse at session end |
| pot_cs_n | output | 1 | Active-low select to the potentiometer |
| pot_up | output | 1 | Direction level to the potentiometer |
| pot_inc | output | 1 | Active-low step strobe to the potentiometer |

## Verification
The assertions assume that commands arrive only through `cmd_valid` and that the reset is held long enough for the timer to clear. They assume nothing about command timing, because a request during a session must be dropped. The stimulus applies a mix of random step counts, directions and store flags from a fixed seed. Directed commands cover zero-step sessions of both kinds and a long run. Some requests are injected mid-session with different fields, so the ignore rule is exercised while the wire timing is still being measured.

// File: rtl/potstep_pkg.sv
package potstep_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ARM,
        ST_SEL,
        ST_DIR,
        ST_LO,
        ST_HI,
        ST_REL,
        ST_HOLD,
        ST_DONE
    } seq_state_e;

    // round a time in ns up to whole cycles of a clock in Hz
    function automatic longint ns_to_cyc(longint t_ns, longint clk_hz);
        longint prod;
        prod = t_ns * clk_hz;
        return (prod + 64'd999_999_999) / 64'd1_000_000_000;
    endfunction

endpackage

// File: rtl/potstep_timer.sv
module potstep_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    AST_TIMER_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);  // R9
endmodule

// File: rtl/potstep_ctrl.sv
module potstep_ctrl
    import potstep_pkg::*;
#(
    parameter int          STEP_W  = 7,
    parameter int          TW      = 8,
    parameter logic [TW-1:0] L_SEL   = '0,
    parameter logic [TW-1:0] L_DIR   = '0,
    parameter logic [TW-1:0] L_LOW   = '0,
    parameter logic [TW-1:0] L_HIGH  = '0,
    parameter logic [TW-1:0] L_REL   = '0,
    parameter logic [TW-1:0] L_STORE = '0,
    parameter logic [TW-1:0] L_SKIP  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [STEP_W-1:0] cmd_steps,
    input  logic              cmd_up,
    input  logic              cmd_store,
    input  logic              tm_zero,
    output logic              tm_load,
    output logic [TW-1:0]     tm_val,
    output logic              busy,
    output logic              done,
    output logic              pot_cs_n,
    output logic              pot_up,
    output logic              pot_inc
);
    typedef struct packed {
        seq_state_e        st;
        logic [STEP_W-1:0] left;
        logic              up;
        logic              store;
        logic              cs_n;
        logic              inc;
        logic              done;
    } regs_t;

    localparam regs_t RESET_VAL = '{st: ST_IDLE, left: '0, up: 1'b0, store: 1'b0,
                                    cs_n: 1'b1, inc: 1'b1, done: 1'b0};

    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tm_load  = 1'b0;
        tm_val   = '0;
        unique case (r_q.st)
            ST_IDLE, ST_DONE: begin
                r_d.st   = ST_IDLE;
                r_d.cs_n = 1'b1;
                r_d.inc  = 1'b1;
                if (cmd_valid) begin
                    r_d.st    = ST_ARM;
                    r_d.left  = cmd_steps;
                    r_d.up    = cmd_up;
                    r_d.store = cmd_store;
                    // a zero-step skip parks the strobe low before select
                    r_d.inc   = !((cmd_steps == '0) && !cmd_store);
                    tm_load   = 1'b1;
                    tm_val    = L_SEL;
                end
            end
            ST_ARM: if (tm_zero) begin
                r_d.st   = ST_SEL;
                r_d.cs_n = 1'b0;
                tm_load  = 1'b1;
                tm_val   = L_SEL;
            end
            ST_SEL: if (tm_zero) begin
                r_d.st  = ST_DIR;
                tm_load = 1'b1;
                tm_val  = L_DIR;
            end
            ST_DIR: if (tm_zero) begin
                tm_load = 1'b1;
                if (r_q.left == '0) begin
                    r_d.st = ST_REL;
                    tm_val = L_REL;
                end else begin
                    r_d.st  = ST_LO;
                    r_d.inc = 1'b0;
                    tm_val  = L_LOW;
                end
            end
            ST_LO: if (tm_zero) begin
                r_d.left = r_q.left - 1'b1;
                tm_load  = 1'b1;
                if ((r_q.left == STEP_W'(1)) && !r_q.store) begin
                    r_d.st = ST_REL;
                    tm_val = L_REL;
                end else begin
                    r_d.st  = ST_HI;
                    r_d.inc = 1'b1;
                    tm_val  = L_HIGH;
                end
            end
            ST_HI: if (tm_zero) begin
                tm_load = 1'b1;
                if (r_q.left == '0) begin
                    r_d.st = ST_REL;
                    tm_val = L_REL;
                end else begin
                    r_d.st  = ST_LO;
                    r_d.inc = 1'b0;
                    tm_val  = L_LOW;
                end
            end
            ST_REL: if (tm_zero) begin
                r_d.st   = ST_HOLD;
                r_d.cs_n = 1'b1;
                tm_load  = 1'b1;
                tm_val   = r_q.store ? L_STORE : L_SKIP;
            end
            ST_HOLD: if (tm_zero) begin
                r_d.st   = ST_DONE;
                r_d.inc  = 1'b1;
                r_d.done = 1'b1;
            end
            default: r_d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    assign busy     = (r_q.st != ST_IDLE) && (r_q.st != ST_DONE);
    assign done     = r_q.done;
    assign pot_cs_n = r_q.cs_n;
    assign pot_up   = r_q.up;
    assign pot_inc  = r_q.inc;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (pot_cs_n && pot_inc));  // R11
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);  // R9
    AST_DIR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!pot_cs_n && $past(!pot_cs_n)) |-> $stable(pot_up));  // R4
    AST_RELEASE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pot_cs_n) |-> (pot_inc == r_q.store));  // R7
    AST_NO_STEP_AT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pot_cs_n) |-> $stable(pot_inc));  // R3
endmodule

// File: rtl/potstep_seq.sv
module potstep_seq
    import potstep_pkg::*;
#(
    parameter longint CLK_HZ     = 125_000_000,
    parameter int     STEP_W     = 7,
    parameter longint T_SEL_NS   = 100,
    parameter longint T_DIR_NS   = 2900,
    parameter longint T_LOW_NS   = 1000,
    parameter longint T_HIGH_NS  = 1000,
    parameter longint T_REL_NS   = 1000,
    parameter longint T_STORE_NS = 20_000_000,
    parameter longint T_SKIP_NS  = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [STEP_W-1:0] cmd_steps,
    input  logic              cmd_up,
    input  logic              cmd_store,
    output logic              busy,
    output logic              done,
    output logic              pot_cs_n,
    output logic              pot_up,
    output logic              pot_inc
);
    localparam longint C_SEL   = ns_to_cyc(T_SEL_NS, CLK_HZ);
    localparam longint C_DIR   = ns_to_cyc(T_DIR_NS, CLK_HZ);
    localparam longint C_LOW   = ns_to_cyc(T_LOW_NS, CLK_HZ);
    localparam longint C_HIGH  = ns_to_cyc(T_HIGH_NS, CLK_HZ);
    localparam longint C_REL   = ns_to_cyc(T_REL_NS, CLK_HZ);
    localparam longint C_STORE = ns_to_cyc(T_STORE_NS, CLK_HZ);
    localparam longint C_SKIP  = ns_to_cyc(T_SKIP_NS, CLK_HZ);
    localparam longint C_MAX   = (C_STORE > C_DIR) ? C_STORE : C_DIR;
    localparam int     TW      = $clog2(C_MAX + 1);

    logic          tm_load;
    logic          tm_zero;
    logic [TW-1:0] tm_val;

    potstep_timer #(.TW(TW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tm_load),
        .load_val (tm_val),
        .zero     (tm_zero)
    );

    potstep_ctrl #(
        .STEP_W  (STEP_W),
        .TW      (TW),
        .L_SEL   (TW'(C_SEL - 1)),
        .L_DIR   (TW'(C_DIR - 1)),
        .L_LOW   (TW'(C_LOW - 1)),
        .L_HIGH  (TW'(C_HIGH - 1)),
        .L_REL   (TW'(C_REL - 1)),
        .L_STORE (TW'(C_STORE - 1)),
        .L_SKIP  (TW'(C_SKIP - 1))
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_steps (cmd_steps),
        .cmd_up    (cmd_up),
        .cmd_store (cmd_store),
        .tm_zero   (tm_zero),
        .tm_load   (tm_load),
        .tm_val    (tm_val),
        .busy      (busy),
        .done      (done),
        .pot_cs_n  (pot_cs_n),
        .pot_up    (pot_up),
        .pot_inc   (pot_inc)
    );
endmodule

// File: tb/potstep_seq_tb_top.sv
module potstep_seq_tb_top;
    localparam longint HZ  = 125_000_000;
    localparam int     SW  = 7;
    localparam longint STO = 8000;

    function automatic int cyc(longint ns);
        return int'((ns * HZ + 64'd999_999_999) / 64'd1_000_000_000);
    endfunction

    localparam int C_SEL   = 13;
    localparam int C_DIR   = 363;
    localparam int C_LOW   = 125;
    localparam int C_HIGH  = 125;
    localparam int C_REL   = 125;
    localparam int C_STORE = 1000;
    localparam int C_SKIP  = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [SW-1:0] cmd_steps = '0;
    logic cmd_up = 1'b0;
    logic cmd_store = 1'b0;
    logic busy, done, pot_cs_n, pot_up, pot_inc;

    always #4 clk = ~clk;

    potstep_seq #(.CLK_HZ(HZ), .STEP_W(SW), .T_STORE_NS(STO)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_steps(cmd_steps),
        .cmd_up(cmd_up), .cmd_store(cmd_store), .busy(busy), .done(done),
        .pot_cs_n(pot_cs_n), .pot_up(pot_up), .pot_inc(pot_inc)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // wire monitor: a behavioural model of the potentiometer plus timing meters
    int  t_cs = 0, t_inc = 0, t_ud = 0;
    int  falls = 0, last_falls = 0, busy_run = 0, last_busy = 0;
    int  pos = 0, stored = 0;
    bit  p_cs = 1, p_inc = 1, p_ud = 0, p_busy = 0, sess_up = 0, rel_inc = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            t_cs++; t_inc++; t_ud++;
            if (busy) busy_run++;
            if (pot_up != p_ud) begin
                chk(pot_cs_n && p_cs, "R4 dir change while selected", int'(pot_cs_n), 1);
                t_ud = 0;
            end
            if (p_inc && !pot_inc && !pot_cs_n) begin
                falls++;
                pos += pot_up ? 1 : -1;
                chk(t_ud >= C_DIR, "R4 dir setup", t_ud, C_DIR);
                if (falls == 1) chk(t_cs >= C_SEL, "R3 select setup", t_cs, C_SEL);
                else            chk(t_inc >= C_HIGH, "R5 high phase", t_inc, C_HIGH);
                t_inc = 0;
            end else if (!p_inc && pot_inc && !pot_cs_n) begin
                chk(t_inc >= C_LOW, "R5 low phase", t_inc, C_LOW);
                t_inc = 0;
            end else if (p_inc != pot_inc) begin
                t_inc = 0;
            end
            if (p_cs && !pot_cs_n) begin
                falls = 0; t_cs = 0; sess_up = pot_up;
            end
            if (!p_cs && pot_cs_n) begin
                chk(t_inc >= C_REL, "R6 release setup", t_inc, C_REL);
                rel_inc = pot_inc;
                last_falls = falls;
                if (pot_inc) stored = pos;
                t_cs = 0;
            end
            if (done) begin
                chk(t_cs >= (rel_inc ? C_STORE : C_SKIP), "R7 deselect hold", t_cs,
                    rel_inc ? C_STORE : C_SKIP);
            end
            if (p_busy && !busy) begin
                last_busy = busy_run;
                busy_run = 0;
            end
            p_cs = pot_cs_n; p_inc = pot_inc; p_ud = pot_up; p_busy = busy;
        end
    end

    function automatic int exp_busy(int n, bit st);
        int h;
        h = st ? n : ((n > 0) ? n - 1 : 0);
        return 2 * C_SEL + C_DIR + n * C_LOW + h * C_HIGH + C_REL + (st ? C_STORE : C_SKIP);
    endfunction

    int exp_pos = 0;
    int exp_stored = 0;

    task automatic run_cmd(int n, bit up, bit st, bit inject);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_steps = SW'(n); cmd_up = up; cmd_store = st;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b1, "R9 busy after accept", int'(busy), 1);
        if (inject) begin
            repeat (40) @(negedge clk);
            cmd_valid = 1'b1; cmd_steps = SW'(n + 3); cmd_up = !up; cmd_store = !st;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(busy == 1'b0, "R9 busy low at done", int'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0, "R9 done single cycle", int'(done), 0);
        exp_pos += up ? n : -n;
        if (st) exp_stored = exp_pos;
        chk(last_falls == n, inject ? "R10 steps with ignored request" : "R2 step count",
            last_falls, n);
        if (n > 0) chk(sess_up == up, "R2 direction level", int'(sess_up), int'(up));
        chk(pos == exp_pos, "R2 wiper position", pos, exp_pos);
        chk(rel_inc == st, "R7 strobe level at release", int'(rel_inc), int'(st));
        chk(stored == exp_stored, n == 0 ? "R8 zero-step store" : "R7 stored position",
            stored, exp_stored);
        chk(last_busy == exp_busy(n, st), inject ? "R10 length with ignored request" :
            "R9 busy length", last_busy, exp_busy(n, st));
        chk(pot_inc && pot_cs_n, "R11 idle levels", int'({pot_cs_n, pot_inc}), 3);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(pot_cs_n && pot_inc && !busy && !done, "R1 reset state",
            int'({pot_cs_n, pot_inc, busy, done}), 4'b1100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(pot_cs_n && pot_inc, "R11 idle after reset", int'({pot_cs_n, pot_inc}), 3);
        // directed corner cases
        run_cmd(3, 1'b1, 1'b1, 1'b0);
        run_cmd(0, 1'b0, 1'b1, 1'b0);   // R8 store-only
        run_cmd(0, 1'b1, 1'b0, 1'b0);   // R8 zero-step skip
        run_cmd(1, 1'b0, 1'b0, 1'b0);
        run_cmd(12, 1'b1, 1'b0, 1'b0);
        run_cmd(2, 1'b0, 1'b1, 1'b1);   // R10
        run_cmd(0, 1'b1, 1'b0, 1'b1);   // R10 zero-step
        for (int i = 0; i < 16; i++) begin
            run_cmd(int'($urandom_range(0, 9)), 1'($urandom), 1'($urandom),
                    ($urandom_range(0, 3) == 0));
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        if (cyc(100) != C_SEL || cyc(2900) != C_DIR || cyc(STO) != C_STORE) begin
            $display("bench cycle table inconsistent");
        end
    end
endmodule